// File: doc/BRIEF.md
# Memory-Attached SHA-1 Hashing Engine

This engine computes the SHA-1 digest of a message that already sits, padded, in a word-addressed synchronous RAM. A one-cycle start pulse captures three operands: how many 512-bit blocks to hash, the RAM address of the first message word, and the RAM address where the digest goes. The engine then reads every block itself, sixteen 32-bit words at a time. It runs the eighty compression rounds at four cycles per round and folds the result into the chaining value. After each block it writes the five-word intermediate digest back to RAM.

Every phase has a fixed length, so the completion time depends only on the block count. Six set-up cycles come first. Each block then costs 347 cycles: 16 to fetch, 320 to compress, 5 to accumulate, 5 to write back and 1 turnaround cycle. A host can therefore schedule around the engine without polling. The digest at the result address is final once done is raised.

Top module: `sha1_mem_engine`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, busy, done, ram_sel and ram_write are all 0.
- R2: A start pulse seen while idle raises busy on the next cycle and clears done on that same cycle.
- R3: For a block count n, done rises exactly 6 + 347·n clock edges after the edge that accepted start, and busy falls on that same edge. busy and done are never high together.
- R4: Word j (0 to 15) of block b is read from address msg_base + 16·b + j. Read data is returned one cycle after the address is presented with ram_sel high.
- R5: Compression follows SHA-1. The chaining value starts from 67452301, EFCDAB89, 98BADCFE, 10325476, C3D2E1F0. Rounds 0–19, 20–39, 40–59 and 60–79 use Ch, Parity, Maj and Parity respectively. The one-block message "abc" gives A9993E36 4706816A BA3E2571 7850C26C 9CD0D89D.
- R6: The chaining value produced by one block is the input of the next, so the two-block message "abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq" gives 84983E44 1C3BD26E BAAE4AA1 F95129E5 E54670F1. A new start begins again from the initial constants.
- R7: After every block, digest word k (0 to 4, most significant first) is written to dig_base + k. There are exactly 5·n writes per run, no other address is written, and ram_write is only high together with ram_sel.
- R8: done stays high until the next accepted start.
- R9: A start pulse while busy is ignored. The run in progress keeps its block count and its latency.
- R10: A block count of 0 raises done exactly 6 cycles after start, without any RAM write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin hashing |
| blk_count | input | BLK_W | Number of 512-bit blocks, captured at start |
| msg_base | input | ADDR_W | Address of the first message word, captured at start |
| dig_base | input | ADDR_W | Address of the first digest word, captured at start |
| ram_rdata | input | 32 | RAM read data, one cycle after the address |
| ram_wdata | output | 32 | RAM write data |
| ram_addr | output | ADDR_W | RAM word address |
| ram_sel | output | 1 | RAM access enable |
| ram_write | output | 1 | RAM write enable (with ram_sel) |
| busy | output | 1 | Engine is working on a request |
| done | output | 1 | Last request finished; held until the next start |

## Verification
The bound checker watches the handshake rules on every cycle. These are: busy rising only after start, busy and done never overlapping, done holding, and writes staying within the five digest addresses under a select. It also counts the cycles of every run and compares the completion edge against 6 + 347·n for the block count latched at acceptance, which covers the zero-block case and ignored start pulses as well. Whether the digest is arithmetically correct, whether chaining across blocks works and whether the fetch addresses are right can only be shown by the bench's known-answer messages. The same holds for the number of RAM writes and for untouched neighbouring RAM words.

// File: rtl/sha1_eng_pkg.sv
package sha1_eng_pkg;

    typedef logic [31:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_INIT, ST_READ, ST_COMP, ST_ADD, ST_WRITE, ST_NEXT
    } phase_e;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
    } wvars_t;

    localparam int INIT_CYC      = 6;
    localparam int WIN           = 16;
    localparam int READ_CYC      = WIN;
    localparam int ROUNDS        = 80;
    localparam int CYC_PER_ROUND = 4;
    localparam int COMP_CYC      = ROUNDS * CYC_PER_ROUND;
    localparam int DIG_WORDS     = 5;
    localparam int ADD_CYC       = DIG_WORDS;
    localparam int WRITE_CYC     = DIG_WORDS;
    localparam int NEXT_CYC      = 1;
    localparam int BLOCK_CYC     = READ_CYC + COMP_CYC + ADD_CYC + WRITE_CYC + NEXT_CYC;
    localparam int CNT_W         = $clog2(COMP_CYC);
    localparam int RND_W         = CNT_W - 2;
    localparam int WIDX_W        = $clog2(WIN);

    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic word_t f_round(input logic [RND_W-1:0] t, input word_t b,
                                      input word_t c, input word_t d);
        if (t < 20)      return (b & c) | (~b & d);
        else if (t < 40) return b ^ c ^ d;
        else if (t < 60) return (b & c) | (b & d) | (c & d);
        else             return b ^ c ^ d;
    endfunction

    function automatic word_t k_round(input logic [RND_W-1:0] t);
        if (t < 20)      return 32'h5A827999;
        else if (t < 40) return 32'h6ED9EBA1;
        else if (t < 60) return 32'h8F1BBCDC;
        else             return 32'hCA62C1D6;
    endfunction

    function automatic word_t iv_word(input logic [2:0] i);
        case (i)
            3'd0:    return 32'h67452301;
            3'd1:    return 32'hEFCDAB89;
            3'd2:    return 32'h98BADCFE;
            3'd3:    return 32'h10325476;
            default: return 32'hC3D2E1F0;
        endcase
    endfunction

    function automatic word_t wvar_pick(input wvars_t v, input logic [2:0] i);
        case (i)
            3'd0:    return v.a;
            3'd1:    return v.b;
            3'd2:    return v.c;
            3'd3:    return v.d;
            default: return v.e;
        endcase
    endfunction

endpackage

// File: rtl/sha1_ctrl.sv
module sha1_ctrl
    import sha1_eng_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BLK_W-1:0]  blk_count,
    input  logic [ADDR_W-1:0] msg_base,
    input  logic [ADDR_W-1:0] dig_base,
    output phase_e            state,
    output logic [CNT_W-1:0]  cnt,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_sel,
    output logic              ram_write,
    output logic              busy,
    output logic              done
);
    logic [BLK_W-1:0]  blk_left;
    logic [ADDR_W-1:0] blk_addr;
    logic [ADDR_W-1:0] res_q;

    function automatic logic at_end(input logic [CNT_W-1:0] c, input int len);
        return c == CNT_W'(len - 1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            blk_left <= '0;
            blk_addr <= '0;
            res_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state    <= ST_INIT;
                    cnt      <= '0;
                    busy     <= 1'b1;
                    done     <= 1'b0;
                    blk_left <= blk_count;
                    blk_addr <= msg_base;
                    res_q    <= dig_base;
                end
                ST_INIT: if (at_end(cnt, INIT_CYC)) begin
                    cnt <= '0;
                    if (blk_left == '0) begin
                        state <= ST_IDLE;
                        busy  <= 1'b0;
                        done  <= 1'b1;
                    end else begin
                        state <= ST_READ;
                    end
                end else cnt <= cnt + 1'b1;
                ST_READ: if (at_end(cnt, READ_CYC)) begin
                    state <= ST_COMP;
                    cnt   <= '0;
                end else cnt <= cnt + 1'b1;
                ST_COMP: if (at_end(cnt, COMP_CYC)) begin
                    state <= ST_ADD;
                    cnt   <= '0;
                end else cnt <= cnt + 1'b1;
                ST_ADD: if (at_end(cnt, ADD_CYC)) begin
                    state <= ST_WRITE;
                    cnt   <= '0;
                end else cnt <= cnt + 1'b1;
                ST_WRITE: if (at_end(cnt, WRITE_CYC)) begin
                    state    <= ST_NEXT;
                    cnt      <= '0;
                    blk_addr <= blk_addr + ADDR_W'(WIN);
                    blk_left <= blk_left - 1'b1;
                end else cnt <= cnt + 1'b1;
                ST_NEXT: begin
                    cnt <= '0;
                    if (blk_left == '0) begin
                        state <= ST_IDLE;
                        busy  <= 1'b0;
                        done  <= 1'b1;
                    end else begin
                        state <= ST_READ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Addresses lead the data by one cycle: word 0 of a block is requested
    // in the cycle before the fetch phase, word j+1 during fetch cycle j.
    always_comb begin
        ram_addr  = '0;
        ram_sel   = 1'b0;
        ram_write = 1'b0;
        case (state)
            ST_INIT: if (at_end(cnt, INIT_CYC) && blk_left != '0) begin
                ram_addr = blk_addr;
                ram_sel  = 1'b1;
            end
            ST_NEXT: if (blk_left != '0) begin
                ram_addr = blk_addr;
                ram_sel  = 1'b1;
            end
            ST_READ: if (!at_end(cnt, READ_CYC)) begin
                ram_addr = blk_addr + ADDR_W'(cnt) + 1'b1;
                ram_sel  = 1'b1;
            end
            ST_WRITE: begin
                ram_addr  = res_q + ADDR_W'(cnt);
                ram_sel   = 1'b1;
                ram_write = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sha1_sched.sv
module sha1_sched
    import sha1_eng_pkg::*;
(
    input  logic              clk,
    input  logic              load_en,
    input  logic [WIDX_W-1:0] load_idx,
    input  word_t             load_data,
    input  logic              step_en,
    input  logic [RND_W-1:0]  t,
    output word_t             wt
);
    word_t w [WIN];
    word_t nw;
    logic  expand;

    assign expand = (t >= RND_W'(WIN));

    // W[t] from W[t-3], W[t-8], W[t-14], W[t-16], all modulo the window size
    assign nw = rotl(w[t[WIDX_W-1:0] + WIDX_W'(13)] ^ w[t[WIDX_W-1:0] + WIDX_W'(8)] ^
                     w[t[WIDX_W-1:0] + WIDX_W'(2)]  ^ w[t[WIDX_W-1:0]], 1);

    for (genvar i = 0; i < WIN; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (load_en && load_idx == WIDX_W'(i))
                w[i] <= load_data;
            else if (step_en && expand && t[WIDX_W-1:0] == WIDX_W'(i))
                w[i] <= nw;
        end
    end

    always_ff @(posedge clk) begin
        if (step_en) wt <= expand ? nw : w[t[WIDX_W-1:0]];
    end

endmodule

// File: rtl/sha1_round.sv
module sha1_round
    import sha1_eng_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             iv_load,
    input  logic             vars_load,
    input  logic             comp_en,
    input  logic [1:0]       sub,
    input  logic [RND_W-1:0] t,
    input  word_t            wt,
    input  logic             add_en,
    input  logic [2:0]       add_idx,
    input  logic [2:0]       rd_idx,
    output word_t            rd_word
);
    wvars_t v;
    word_t  h [DIG_WORDS];
    word_t  s1;
    word_t  s2;

    // Round split: sub 0 schedule, 1 e+K+W, 2 add f, 3 shift the variables.
    always_ff @(posedge clk) begin
        if (rst) begin
            v  <= '0;
            s1 <= '0;
            s2 <= '0;
        end else if (vars_load) begin
            v <= '{a: h[0], b: h[1], c: h[2], d: h[3], e: h[4]};
        end else if (comp_en) begin
            case (sub)
                2'd1: s1 <= v.e + k_round(t) + wt;
                2'd2: s2 <= s1 + f_round(t, v.b, v.c, v.d);
                2'd3: v  <= '{a: rotl(v.a, 5) + s2, b: v.a, c: rotl(v.b, 30),
                              d: v.c, e: v.d};
                default: ;
            endcase
        end
    end

    for (genvar k = 0; k < DIG_WORDS; k++) begin : g_hash
        always_ff @(posedge clk) begin
            if (rst)
                h[k] <= '0;
            else if (iv_load)
                h[k] <= iv_word(3'(k));
            else if (add_en && add_idx == 3'(k))
                h[k] <= h[k] + wvar_pick(v, 3'(k));
        end
    end

    always_comb begin
        case (rd_idx)
            3'd0:    rd_word = h[0];
            3'd1:    rd_word = h[1];
            3'd2:    rd_word = h[2];
            3'd3:    rd_word = h[3];
            3'd4:    rd_word = h[4];
            default: rd_word = '0;
        endcase
    end

endmodule

// File: rtl/sha1_mem_engine.sv
module sha1_mem_engine
    import sha1_eng_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BLK_W-1:0]  blk_count,
    input  logic [ADDR_W-1:0] msg_base,
    input  logic [ADDR_W-1:0] dig_base,
    input  logic [31:0]       ram_rdata,
    output logic [31:0]       ram_wdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_sel,
    output logic              ram_write,
    output logic              busy,
    output logic              done
);
    phase_e           state;
    logic [CNT_W-1:0] cnt;
    logic [RND_W-1:0] rnd;
    logic [1:0]       sub;
    word_t            wt;
    word_t            hword;

    assign rnd = cnt[CNT_W-1:2];
    assign sub = cnt[1:0];

    sha1_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .blk_count (blk_count),
        .msg_base  (msg_base),
        .dig_base  (dig_base),
        .state     (state),
        .cnt       (cnt),
        .ram_addr  (ram_addr),
        .ram_sel   (ram_sel),
        .ram_write (ram_write),
        .busy      (busy),
        .done      (done)
    );

    sha1_sched u_sched (
        .clk       (clk),
        .load_en   (state == ST_READ),
        .load_idx  (cnt[WIDX_W-1:0]),
        .load_data (ram_rdata),
        .step_en   (state == ST_COMP && sub == 2'd0),
        .t         (rnd),
        .wt        (wt)
    );

    sha1_round u_round (
        .clk       (clk),
        .rst       (rst),
        .iv_load   (state == ST_INIT),
        .vars_load (state == ST_READ && cnt == CNT_W'(READ_CYC - 1)),
        .comp_en   (state == ST_COMP),
        .sub       (sub),
        .t         (rnd),
        .wt        (wt),
        .add_en    (state == ST_ADD),
        .add_idx   (cnt[2:0]),
        .rd_idx    (cnt[2:0]),
        .rd_word   (hword)
    );

    assign ram_wdata = ram_write ? hword : 32'h0;

endmodule

// File: rtl/sha1_mem_engine_chk.sv
module sha1_mem_engine_chk
    import sha1_eng_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [BLK_W-1:0]  blk_count,
    input logic [ADDR_W-1:0] dig_base,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_sel,
    input logic              ram_write,
    input logic              busy,
    input logic              done
);
    logic [31:0]       run_cyc;
    logic [BLK_W-1:0]  nblk_q;
    logic [ADDR_W-1:0] res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cyc <= '0;
            nblk_q  <= '0;
            res_q   <= '0;
        end else if (start && !busy) begin
            run_cyc <= '0;
            nblk_q  <= blk_count;
            res_q   <= dig_base;
        end else if (busy) begin
            run_cyc <= run_cyc + 1'b1;
        end
    end

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R3
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R3 R9 R10
    latency_exact_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> run_cyc == 32'(INIT_CYC) + 32'(BLOCK_CYC) * 32'(nblk_q));

    // R7
    write_sel_chk: assert property (@(posedge clk) disable iff (rst)
        ram_write |-> (ram_sel && busy));

    // R7
    write_range_chk: assert property (@(posedge clk) disable iff (rst)
        ram_write |-> (ram_addr - res_q) < ADDR_W'(DIG_WORDS));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

endmodule

bind sha1_mem_engine sha1_mem_engine_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .blk_count (blk_count),
    .dig_base  (dig_base),
    .ram_addr  (ram_addr),
    .ram_sel   (ram_sel),
    .ram_write (ram_write),
    .busy      (busy),
    .done      (done)
);

// File: tb/sha1_mem_engine_test.sv
module sha1_mem_engine_test;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 16;
    localparam int BLK_W  = 16;

    typedef struct packed {
        logic [15:0]  nblk;
        logic [15:0]  base;
        logic [15:0]  res;
        logic         poke;
        logic [159:0] dig;
    } vec_t;

    localparam vec_t VECS [3] = '{
        '{nblk: 16'd1, base: 16'd0,  res: 16'd64,  poke: 1'b0,
          dig: 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D},
        '{nblk: 16'd2, base: 16'd16, res: 16'd80,  poke: 1'b1,
          dig: 160'h84983E44_1C3BD26E_BAAE4AA1_F95129E5_E54670F1},
        '{nblk: 16'd1, base: 16'd0,  res: 16'd100, poke: 1'b0,
          dig: 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [BLK_W-1:0]  blk_count = '0;
    logic [ADDR_W-1:0] msg_base = '0;
    logic [ADDR_W-1:0] dig_base = '0;
    logic [31:0]       ram_rdata;
    logic [31:0]       ram_wdata;
    logic [ADDR_W-1:0] ram_addr;
    logic              ram_sel;
    logic              ram_write;
    logic              busy;
    logic              done;

    logic [31:0] mem [256];
    int          wr_cnt = 0;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_P / 2) clk = ~clk;

    always @(posedge clk) begin
        if (ram_sel && ram_write) begin
            mem[ram_addr[7:0]] <= ram_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (ram_sel) ram_rdata <= mem[ram_addr[7:0]];
    end

    sha1_mem_engine #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) uut (
        .clk(clk), .rst(rst), .start(start), .blk_count(blk_count),
        .msg_base(msg_base), .dig_base(dig_base), .ram_rdata(ram_rdata),
        .ram_wdata(ram_wdata), .ram_addr(ram_addr), .ram_sel(ram_sel),
        .ram_write(ram_write), .busy(busy), .done(done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Runs one request; returns the measured latency in edges.
    task automatic run(input int n, input int base, input int res, input bit poke,
                       output int cycles, output bit busy_gap, output int writes);
        @(negedge clk);
        blk_count = BLK_W'(n);
        msg_base  = ADDR_W'(base);
        dig_base  = ADDR_W'(res);
        start     = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        wr_cnt = 0;
        check("R2 busy after start", 32'(busy), 32'd1);
        check("R2 done cleared by start", 32'(done), 32'd0);
        cycles   = 0;
        busy_gap = 1'b0;
        while (!done && cycles < 5000) begin
            @(negedge clk);
            cycles++;
            if (poke && cycles == 100) begin
                start     = 1'b1;
                blk_count = BLK_W'(5);
            end else if (poke && cycles == 101) begin
                start = 1'b0;
            end
            if (!done && !busy) busy_gap = 1'b1;
        end
        writes = wr_cnt;
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int  cyc;
        bit  gap;
        int  nw;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        // "abc" padded at 0..15
        mem[0]  = 32'h61626380;
        mem[15] = 32'h00000018;
        // 56-char message padded over 16..47
        for (int i = 0; i < 14; i++)
            mem[16 + i] = {8'(8'h61 + i), 8'(8'h62 + i), 8'(8'h63 + i), 8'(8'h64 + i)};
        mem[30] = 32'h80000000;
        mem[47] = 32'h000001C0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 busy in reset", 32'(busy), 32'd0);
        check("R1 done in reset", 32'(done), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", 32'(busy), 32'd0);
        check("R1 done after reset", 32'(done), 32'd0);
        check("R1 ram_sel after reset", 32'(ram_sel), 32'd0);
        check("R1 ram_write after reset", 32'(ram_write), 32'd0);

        foreach (VECS[v]) begin
            mem[VECS[v].res + 5]        = 32'hDEADBEEF;
            mem[VECS[v].res - 1] = 32'hFEEDF00D;
            run(int'(VECS[v].nblk), int'(VECS[v].base), int'(VECS[v].res),
                VECS[v].poke, cyc, gap, nw);
            // R3 R9: exact latency, stray start ignored on the poked vector
            check("R3 R9 done latency", 32'(cyc), 32'(6 + 347 * int'(VECS[v].nblk)));
            check("R3 busy falls with done", 32'(busy), 32'd0);
            check("R3 busy held during run", 32'(gap), 32'd0);
            check("R7 write count", 32'(nw), 32'(5 * int'(VECS[v].nblk)));
            for (int k = 0; k < 5; k++)
                check(VECS[v].nblk == 1 ? "R4 R5 digest word" : "R4 R6 digest word",
                      mem[VECS[v].res + k], VECS[v].dig[159 - 32 * k -: 32]);
            check("R7 word above digest untouched", mem[VECS[v].res + 5], 32'hDEADBEEF);
            check("R7 word below digest untouched", mem[VECS[v].res - 1], 32'hFEEDF00D);
            check("R7 message intact", mem[0], 32'h61626380);
            // R8: done holds while idle
            repeat (20) @(negedge clk);
            check("R8 done held", 32'(done), 32'd1);
        end

        // R10: zero blocks
        mem[120] = 32'h0BADCAFE;
        run(0, 0, 120, 1'b0, cyc, gap, nw);
        check("R10 zero-block latency", 32'(cyc), 32'd6);
        check("R10 zero-block writes", 32'(nw), 32'd0);
        check("R10 result region untouched", mem[120], 32'h0BADCAFE);
        check("R10 done raised", 32'(done), 32'd1);

        finish_run();
    end

endmodule